// File: doc/BRIEF.md
# Buffered PWM Compare Register Bank

This block keeps a software-visible shadow copy and a hardware-visible active copy of the seven values that drive a three-phase, center-aligned PWM timer. These are the counter period, the duty thresholds of phases U, V and W, an event-thinning setting, and two converter trigger points. The CPU writes the shadow copies through a small address/data port. The comparators and the trigger logic read every active value at once from one flat output bus. Reads through the CPU port always return the shadow copy.

Three update policies are chosen by two mode inputs. In immediate mode each written value goes straight to its active register. In the two batch modes nothing reaches the active side until the CPU writes the phase-U duty register. That write arms a single transfer that copies all seven shadow values together at the next counter turning point. A turning point is a period match (peak) or a count of one (trough), taken only while the counter step pulse is high. In the thinned batch mode the transfer waits for a turning point that the event thinner lets through. The thinner passes one event and then swallows the next N, where N is the low five bits of the active thinning register.

Top module: `pwm_shadow_bank`

## Requirements
- R1: While reset is low at a clock edge, every shadow value, every active value, the armed state and the thinning counter return to zero.
- R2: With `upd_imm` at 1, a write updates that register's active value at the same edge as its shadow value, leaves the other active values alone, and ignores `upd_reload`.
- R3: With `upd_imm` at 0, writes to addresses 0 and 2 to 6 change only the shadow side. The active side does not move at turning points while no transfer is armed.
- R4: With `upd_imm` at 0, a write to address 1 (phase-U duty) arms a transfer. At the next qualifying turning point all seven active values take the shadow values held before that edge, in a single edge.
- R5: A turning point is a clock edge with `cnt_step` high and `cnt_val` equal either to the active period (address 0) or to 16'h0001. With `cnt_step` low, a match is not a turning point.
- R6: The armed state clears on the edge that transfers, so a later turning point without a new phase-U write transfers nothing.
- R7: A phase-U write on the transfer edge is stored in the shadow copy and re-arms. The value it carries reaches the active side at the following turning point.
- R8: With `upd_imm` at 0 and `upd_reload` at 1, only turning points passed by the thinner transfer. The thinner counts every turning point in every mode. It passes one, then suppresses as many as the active thinning register's bits [4:0] held when it passed. A value of 0 passes all.
- R9: `rd_data` returns the shadow value at `rd_addr` for addresses 0 to 6 and zero for address 7. Writes to address 7 change nothing.
- R10: With `upd_imm` at 0 and `upd_reload` at 0, every turning point qualifies, whatever the thinning ratio holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 3 | Write address (0 period, 1 duty U, 2 duty V, 3 duty W, 4 thinning, 5 trigger A, 6 trigger B) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Shadow value at `rd_addr` |
| cnt_val | input | 16 | Current timer count |
| cnt_step | input | 1 | One-cycle pulse marking a valid counter value |
| upd_imm | input | 1 | 1 selects immediate update |
| upd_reload | input | 1 | 1 selects thinned batch update when `upd_imm` is 0 |
| act_all | output | 112 | Active values, register k at bits [16k+15:16k] |

## Verification
The hardest situation to reach is a thinned transfer. It needs a thinning ratio already on the active side, which can only get there through an earlier batch transfer, and it needs the thinner's skip counter in a known phase. The bench loads the ratio with an unthinned batch transfer first. It then switches to thinned mode, re-arms immediately after each transfer, and counts turning points until the next copy. The coincident phase-U write on a transfer edge is driven on purpose, and a long random run mixes modes, writes and counter values clustered on the period and on one.

// File: rtl/pwm_bank_pkg.sv
// Package: shared constants and the update-policy type for the buffered
// PWM compare bank. Assumes a 3-bit register address space with seven
// live registers; address 7 is unused.
package pwm_bank_pkg;

    localparam int NREG      = 7;
    localparam int ADDR_W    = 3;
    localparam int A_PERIOD  = 0;
    localparam int A_DUTY_U  = 1;
    localparam int A_THIN    = 4;

    typedef enum logic [1:0] {
        UPD_IMMEDIATE = 2'd0,
        UPD_BATCH     = 2'd1,
        UPD_THINNED   = 2'd2
    } upd_mode_e;

    // Derive the active update policy from the two mode inputs.
    function automatic upd_mode_e decode_mode(input logic imm, input logic reload);
        if (imm)
            return UPD_IMMEDIATE;
        else if (reload)
            return UPD_THINNED;
        else
            return UPD_BATCH;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
// Module: shadow/active register pairs. Each pair has its own write decode.
// The active side either follows a write directly (immediate policy) or
// copies the shadow on a transfer pulse. Assumes xfer is never high while
// imm is high.
module pwm_bank_regs #(
    parameter int DATA_W = 16,
    parameter int NREG   = 7,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   imm,
    input  logic                   xfer,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NREG*DATA_W-1:0] act_flat
);

    logic [DATA_W-1:0] shadow_q [NREG];
    logic [DATA_W-1:0] active_q [NREG];
    logic [NREG-1:0]   wr_hit;

    for (genvar k = 0; k < NREG; k++) begin : g_pair
        // Decode a write aimed at this register.
        assign wr_hit[k] = wr_en && (wr_addr == ADDR_W'(k));

        // Hold the CPU-written shadow value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[k] <= '0;
            else if (wr_hit[k])
                shadow_q[k] <= wr_data;
        end

        // Update the active value by direct write or batch copy.
        always_ff @(posedge clk) begin
            if (!rst_n)
                active_q[k] <= '0;
            else if (imm && wr_hit[k])
                active_q[k] <= wr_data;
            else if (xfer)
                active_q[k] <= shadow_q[k];
        end

        assign act_flat[k*DATA_W +: DATA_W] = active_q[k];
    end

    // Select the shadow value for a CPU read; unused addresses give zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++) begin
            if (rd_addr == ADDR_W'(k))
                rd_data = shadow_q[k];
        end
    end

endmodule

// File: rtl/pwm_bank_events.sv
// Module: turning-point detector and event thinner. A turning point is a
// stepped counter value equal to the period or to one. The thinner passes
// one turning point, then swallows the next `ratio`. Assumes cnt_step is a
// single-cycle qualifier per counter value.
module pwm_bank_events #(
    parameter int DATA_W = 16,
    parameter int THIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_step,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic [DATA_W-1:0] period,
    input  logic [THIN_W-1:0] ratio,
    output logic              evt,
    output logic              evt_pass
);

    localparam logic [DATA_W-1:0] TROUGH = DATA_W'(1);

    logic              peak_hit;
    logic              trough_hit;
    logic [THIN_W-1:0] skip_q;

    // Compare the counter against both turning values.
    always_comb begin
        peak_hit   = (cnt_val == period);
        trough_hit = (cnt_val == TROUGH);
        evt        = cnt_step && (peak_hit || trough_hit);
        evt_pass   = evt && (skip_q == '0);
    end

    // Count down suppressed events; reload the ratio on each passed one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            skip_q <= '0;
        else if (evt_pass)
            skip_q <= ratio;
        else if (evt)
            skip_q <= skip_q - 1'b1;
    end

endmodule

// File: rtl/pwm_bank_arm.sv
// Module: transfer arming. A phase-U write arms a batch copy, and the copy
// fires at the next turning point the current policy accepts. The armed
// flag drops on the firing edge unless a new phase-U write lands on it.
// Assumes mode is decoded from the same-cycle mode inputs.
module pwm_bank_arm
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  upd_mode_e mode,
    input  logic      u_wr,
    input  logic      evt,
    input  logic      evt_pass,
    output logic      armed,
    output logic      xfer
);

    logic point_ok;

    // Pick which turning points count under the active policy.
    always_comb begin
        unique case (mode)
            UPD_BATCH:   point_ok = evt;
            UPD_THINNED: point_ok = evt_pass;
            default:     point_ok = 1'b0;
        endcase
        xfer = armed && point_ok;
    end

    // Set on a phase-U write, clear on transfer or in immediate policy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (mode == UPD_IMMEDIATE)
            armed <= 1'b0;
        else if (u_wr)
            armed <= 1'b1;
        else if (xfer)
            armed <= 1'b0;
    end

endmodule

// File: rtl/pwm_shadow_bank.sv
// Module: top of the buffered compare bank. It ties the register pairs,
// the turning-point detector and the arming logic together. The period and
// thinning ratio fed back into the detector come from the active side.
module pwm_shadow_bank
    import pwm_bank_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int THIN_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [DATA_W-1:0]      cnt_val,
    input  logic                   cnt_step,
    input  logic                   upd_imm,
    input  logic                   upd_reload,
    output logic [NREG*DATA_W-1:0] act_all
);

    upd_mode_e         mode;
    logic              u_wr;
    logic              evt;
    logic              evt_pass;
    logic              armed;
    logic              xfer_go;
    logic [DATA_W-1:0] period;
    logic [THIN_W-1:0] ratio;

    // Decode the policy and the arming write; tap the fed-back values.
    always_comb begin
        mode   = decode_mode(upd_imm, upd_reload);
        u_wr   = wr_en && (wr_addr == ADDR_W'(A_DUTY_U));
        period = act_all[A_PERIOD*DATA_W +: DATA_W];
        ratio  = act_all[A_THIN*DATA_W +: THIN_W];
    end

    pwm_bank_regs #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .imm      (upd_imm),
        .xfer     (xfer_go),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .act_flat (act_all)
    );

    pwm_bank_events #(
        .DATA_W (DATA_W),
        .THIN_W (THIN_W)
    ) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_step (cnt_step),
        .cnt_val  (cnt_val),
        .period   (period),
        .ratio    (ratio),
        .evt      (evt),
        .evt_pass (evt_pass)
    );

    pwm_bank_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .u_wr     (u_wr),
        .evt      (evt),
        .evt_pass (evt_pass),
        .armed    (armed),
        .xfer     (xfer_go)
    );

endmodule

// File: rtl/pwm_shadow_bank_chk.sv
// Checker: temporal properties of the compare bank, bound to the top.
module pwm_shadow_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [DATA_W-1:0]      wr_data,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic [DATA_W-1:0]      rd_data,
    input logic                   upd_imm,
    input logic                   upd_reload,
    input logic [NREG*DATA_W-1:0] act_all,
    input logic                   armed,
    input logic                   xfer_go,
    input logic                   evt_pass
);

    logic [DATA_W-1:0] act_w [2**ADDR_W];

    // Unpack the active bus; the unused address reads as zero.
    always_comb begin
        for (int k = 0; k < 2**ADDR_W; k++)
            act_w[k] = (k < NREG) ? act_all[k*DATA_W +: DATA_W] : '0;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (act_all == '0) && !armed);

    p_imm_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_imm && wr_en && wr_addr != 3'd7) |=> act_w[$past(wr_addr)] == $past(wr_data));

    p_hold_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_imm && !xfer_go) |=> $stable(act_all));

    p_xfer_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> armed && !upd_imm);

    p_xfer_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && !(wr_en && wr_addr == 3'd1)) |=> !armed);

    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_imm && wr_en && wr_addr == 3'd1) |=> armed);

    p_thin_only_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && upd_reload) |-> evt_pass);

    p_read_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 3'd7) |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));

    p_read_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd7) |-> rd_data == '0);

endmodule

bind pwm_shadow_bank pwm_shadow_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .upd_imm    (upd_imm),
    .upd_reload (upd_reload),
    .act_all    (act_all),
    .armed      (armed),
    .xfer_go    (xfer_go),
    .evt_pass   (evt_pass)
);

// File: tb/sim_pwm_shadow_bank.sv
module sim_pwm_shadow_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [15:0]  rd_data;
    logic [15:0]  cnt_val = '0;
    logic         cnt_step = 1'b0;
    logic         upd_imm = 1'b0;
    logic         upd_reload = 1'b0;
    logic [111:0] act_all;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    // Behavioural reference state
    logic [15:0] m_sh [7];
    logic [15:0] m_ac [7];
    bit          m_arm;
    int          m_skip;

    always #2 clk = ~clk;

    pwm_shadow_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_val(cnt_val), .cnt_step(cnt_step), .upd_imm(upd_imm),
        .upd_reload(upd_reload), .act_all(act_all)
    );

    function automatic logic [15:0] act_of(int k);
        return act_all[16*k +: 16];
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Reference model: next state from the requirements, every edge.
    always @(posedge clk) begin
        logic [15:0] osh [7];
        bit ev, pass, xf, thin;
        osh = m_sh;
        if (!rst_n) begin
            foreach (m_sh[k]) begin m_sh[k] = '0; m_ac[k] = '0; end
            m_arm = 0; m_skip = 0;
        end else begin
            ev   = cnt_step && (cnt_val == m_ac[0] || cnt_val == 16'h0001);
            pass = ev && (m_skip == 0);
            thin = !upd_imm && upd_reload;
            xf   = !upd_imm && m_arm && (thin ? pass : ev);
            if (ev) m_skip = pass ? int'(m_ac[4][4:0]) : m_skip - 1;
            if (upd_imm) begin
                if (wr_en && wr_addr != 3'd7) m_ac[wr_addr] = wr_data;
            end else if (xf) begin
                m_ac = osh;
            end
            if (wr_en && wr_addr != 3'd7) m_sh[wr_addr] = wr_data;
            if (upd_imm) m_arm = 0;
            else m_arm = (m_arm && !xf) || (wr_en && wr_addr == 3'd1);
        end
    end

    // Compare every active value and the read port on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 7; k++) chk({cur_req, " active"}, act_of(k), m_ac[k]);
            chk({cur_req, " read"}, rd_data, (rd_addr == 3'd7) ? 16'h0 : m_sh[rd_addr]);
        end
    end

    task automatic cyc(bit we, logic [2:0] a, logic [15:0] d, bit stp, logic [15:0] cv);
        wr_en = we; wr_addr = a; wr_data = d; cnt_step = stp; cnt_val = cv;
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        cyc(1, a, d, 0, 16'h0007);
    endtask

    task automatic idle_evt(logic [15:0] cv);
        cyc(0, 3'd0, 16'h0, 1, cv);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int n;
        @(negedge clk); #1;
        repeat (3) cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);
        // R1: everything zero after reset
        for (int k = 0; k < 7; k++) chk("R1 reset active", act_of(k), 16'h0);
        chk("R1 reset read", rd_data, 16'h0);

        // R2: immediate updates, reload select ignored
        cur_req = "R2"; upd_imm = 1; upd_reload = 1;
        wr(0, 16'd20); wr(4, 16'd0); wr(2, 16'h0100);
        wr(3, 16'h1234);
        chk("R2 immediate", act_of(3), 16'h1234);
        chk("R2 others kept", act_of(2), 16'h0100);
        idle_evt(16'd20); idle_evt(16'd1);

        // R3: batch, non-U writes stay in shadow
        cur_req = "R3"; upd_imm = 0; upd_reload = 0;
        wr(2, 16'h0AAA);
        idle_evt(16'd20);
        chk("R3 unarmed hold", act_of(2), 16'h0100);

        // R4/R5: arm by U write, transfer at trough; step qualifies
        cur_req = "R4"; wr(1, 16'h0777);
        idle_evt(16'd7);
        chk("R5 non-match", act_of(1), 16'h0000);
        cyc(0, 0, 0, 0, 16'd20);
        chk("R5 no step", act_of(1), 16'h0000);
        idle_evt(16'd1);
        chk("R4 U copied", act_of(1), 16'h0777);
        chk("R4 V copied", act_of(2), 16'h0AAA);

        // R6: armed clears after transfer
        cur_req = "R6"; wr(3, 16'h0333);
        idle_evt(16'd20);
        chk("R6 no second copy", act_of(3), 16'h1234);

        // R7: U write on the transfer edge re-arms
        cur_req = "R7"; wr(1, 16'h0444);
        cyc(1, 3'd1, 16'h0555, 1, 16'd20);
        chk("R7 old value copied", act_of(1), 16'h0444);
        chk("R7 W copied", act_of(3), 16'h0333);
        idle_evt(16'd1);
        chk("R7 rearm copy", act_of(1), 16'h0555);

        // R10: batch with a nonzero ratio still takes every point
        cur_req = "R10"; wr(4, 16'd2); wr(1, 16'h0600);
        idle_evt(16'd20);
        chk("R10 ratio loaded", act_of(4), 16'd2);
        wr(1, 16'h0601);
        idle_evt(16'd1);
        chk("R10 next point", act_of(1), 16'h0601);

        // R8: thinned mode, ratio 2 -> one transfer every third point
        cur_req = "R8"; upd_reload = 1;
        wr(1, 16'h0700);
        n = 0;
        while (act_of(1) != 16'h0700 && n < 10) begin idle_evt(n[0] ? 16'd1 : 16'd20); n++; end
        for (int r = 0; r < 2; r++) begin
            wr(1, 16'h0710 + 16'(r));
            n = 0;
            while (act_of(1) != 16'h0710 + 16'(r) && n < 10) begin
                idle_evt(n[0] ? 16'd1 : 16'd20); n++;
            end
            chk("R8 events per transfer", 16'(n), 16'd3);
        end

        // R9: reads return shadow, address 7 inert
        cur_req = "R9"; upd_reload = 0;
        wr(5, 16'hBEEF);
        rd_addr = 3'd5; cyc(0, 0, 0, 0, 0);
        chk("R9 shadow read", rd_data, 16'hBEEF);
        chk("R9 active kept", act_of(5), 16'h0000);
        wr(7, 16'hFFFF);
        rd_addr = 3'd7; cyc(0, 0, 0, 0, 0);
        chk("R9 unused read", rd_data, 16'h0000);

        // Mixed random run, compared by the model each cycle
        cur_req = "R4 R8 mixed";
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] cv;
            int sel;
            sel = $urandom_range(0, 3);
            cv = (sel == 0) ? 16'd1 : (sel == 1) ? act_of(0) : 16'($urandom_range(0, 40));
            if (i % 500 == 0) begin
                upd_imm = ($urandom_range(0, 5) == 0);
                upd_reload = $urandom_range(0, 1) != 0;
            end
            rd_addr = 3'($urandom_range(0, 7));
            cyc($urandom_range(0, 3) == 0, 3'($urandom_range(0, 7)),
                16'($urandom_range(0, 31)), $urandom_range(0, 3) != 0, cv);
        end
        summary();
    end

endmodule